// File: doc/BRIEF.md
# Four-Channel Prescaled Pulse-Width Modulator

This block is a pulse-width modulator with four independent outputs. Software sets it up through a simple register port: a write strobe, a read strobe, a byte address and a 32-bit data word, with every access done in a single cycle. Each channel has a bank of three registers. The control register holds an enable bit and a 14-bit prescale value. The duty register and the period register each hold a 16-bit count. A channel's output is high for `(prescale+1) × duty` clock cycles out of every `(prescale+1) × period` cycles.

A single global enable sits above the per-channel enables. Setting the global enable lets the channels that are individually enabled run. Clearing it stops every channel at once. Settings that software changes while a channel runs are held back until the current period ends, so no pulse is ever truncated or stretched by a register write.

Top module: `pwm_quad`

## Requirements
- R1: After reset, every mapped register reads back zero and all four outputs are low.
- R2: Channel n's bank starts at byte address n×0x10. Within a bank, offset 0x0 is control, 0x4 is duty and 0x8 is period. The global enable register sits at 0x3C. A read of any other address returns zero, and a write to any other address changes no register.
- R3: The control register reads back all 32 bits exactly as written. Duty and period read back their low 16 bits, with the upper bits zero. The global enable register reads back bit 0 only.
- R4: Control bit 0 is the channel enable. Control bits 15:2 hold the prescale value, from 0 to 0x3FFF.
- R5: When duty is less than period, a running channel's output is high for (prescale+1)×duty cycles in each period of (prescale+1)×period cycles, and each period starts with the high phase.
- R6: When duty is greater than or equal to period, a running channel's output stays high continuously.
- R7: When a channel's enable is clear, its output is low. Its prescale and period counters restart, so the first period after it is enabled again is a complete one.
- R8: When bit 0 of the global enable is clear, all outputs are low, whatever the channel enables are.
- R9: A change to duty, period or prescale written during a period takes effect only from the next period boundary.
- R10: Channels run at the same time with independent settings and do not affect one another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe |
| addr | input | 8 | Byte address of the access |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data, valid in the cycle rdEn is high, zero otherwise |
| pwmOut | output | 4 | One modulated output per channel |

## Verification
The waveform is exercised with a table of settings that spreads across all four channels. The table covers a zero prescale, small and large prescales, a one-count high time and duty values at or above the period. Measuring both the high time and the full period tells a prescaler that is off by one apart from a duty comparison that is off by one, and it also separates the continuous-high case from the normal pulse shape. Directed patterns check three timing behaviours: a duty write in the middle of a pulse must leave that pulse intact, a channel re-enabled in the middle of a period must start a full fresh pulse, and toggling the global enable must silence a channel that is enabled. Two channels running at once with different settings expose any sharing of counters between channels.

// File: rtl/pwm_quad_pkg.sv
`timescale 1ns/1ps
package pwm_quad_pkg;
  localparam int PRE_W = 14;
  localparam int CNT_W = 16;

  // Settings handed from the register bank to one channel datapath
  typedef struct packed {
    logic             run;
    logic [PRE_W-1:0] pre;
    logic [CNT_W-1:0] duty;
    logic [CNT_W-1:0] period;
  } chanCfg_t;
endpackage

// File: rtl/pwm_quad_regs.sv
`timescale 1ns/1ps
module pwm_quad_regs
  import pwm_quad_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   wrEn,
  input  logic                   rdEn,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [DATA_W-1:0]      wrData,
  output logic [DATA_W-1:0]      rdData,
  output chanCfg_t [NUM_CH-1:0]  cfg,
  output logic                   masterOn,
  output logic [NUM_CH-1:0]      chanOn
);
  localparam int BANK_W = ADDR_W - 4;
  localparam logic [3:0] OFF_CTRL = 4'h0;
  localparam logic [3:0] OFF_DUTY = 4'h4;
  localparam logic [3:0] OFF_PER  = 4'h8;
  localparam logic [ADDR_W-1:0] MASTER_ADDR = ADDR_W'(8'h3C);

  logic [DATA_W-1:0] ctrlReg [NUM_CH];
  logic [CNT_W-1:0]  dutyReg [NUM_CH];
  logic [CNT_W-1:0]  perReg  [NUM_CH];
  logic              masterReg;

  logic [BANK_W-1:0] bankSel;
  logic [3:0]        regOff;
  assign bankSel = addr[ADDR_W-1:4];
  assign regOff  = addr[3:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      masterReg <= 1'b0;
      for (int i = 0; i < NUM_CH; i++) begin
        ctrlReg[i] <= '0;
        dutyReg[i] <= '0;
        perReg[i]  <= '0;
      end
    end else if (wrEn) begin
      if (addr == MASTER_ADDR) masterReg <= wrData[0];
      for (int i = 0; i < NUM_CH; i++) begin
        if (bankSel == BANK_W'(i)) begin
          case (regOff)
            OFF_CTRL: ctrlReg[i] <= wrData;
            OFF_DUTY: dutyReg[i] <= wrData[CNT_W-1:0];
            OFF_PER:  perReg[i]  <= wrData[CNT_W-1:0];
            default: ;
          endcase
        end
      end
    end
  end

  always_comb begin
    rdData = '0;
    if (rdEn) begin
      if (addr == MASTER_ADDR) rdData = DATA_W'(masterReg);
      for (int i = 0; i < NUM_CH; i++) begin
        if (bankSel == BANK_W'(i)) begin
          case (regOff)
            OFF_CTRL: rdData = ctrlReg[i];
            OFF_DUTY: rdData = DATA_W'(dutyReg[i]);
            OFF_PER:  rdData = DATA_W'(perReg[i]);
            default: ;
          endcase
        end
      end
    end
  end

  assign masterOn = masterReg;

  always_comb begin
    for (int i = 0; i < NUM_CH; i++) begin
      chanOn[i]     = ctrlReg[i][0];
      cfg[i].run    = masterReg & ctrlReg[i][0];
      cfg[i].pre    = ctrlReg[i][2 +: PRE_W];
      cfg[i].duty   = dutyReg[i];
      cfg[i].period = perReg[i];
    end
  end
endmodule

// File: rtl/pwm_quad_chan.sv
`timescale 1ns/1ps
module pwm_quad_chan
  import pwm_quad_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  chanCfg_t cfg,
  output logic     pwmOut
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic             active;
  logic [PRE_W-1:0] preCnt, actPre;
  logic [CNT_W-1:0] perCnt, actDuty, actPer;
  logic             tickEnd, perEnd;

  assign tickEnd = (preCnt == actPre);
  assign perEnd  = (perCnt == actPer - ONE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active  <= 1'b0;
      preCnt  <= '0;
      perCnt  <= '0;
      actPre  <= '0;
      actDuty <= '0;
      actPer  <= '0;
    end else if (!cfg.run) begin
      active <= 1'b0;
      preCnt <= '0;
      perCnt <= '0;
    end else if (!active) begin
      active  <= 1'b1;
      preCnt  <= '0;
      perCnt  <= '0;
      actPre  <= cfg.pre;
      actDuty <= cfg.duty;
      actPer  <= cfg.period;
    end else if (tickEnd) begin
      preCnt <= '0;
      if (perEnd) begin
        perCnt  <= '0;
        actPre  <= cfg.pre;
        actDuty <= cfg.duty;
        actPer  <= cfg.period;
      end else begin
        perCnt <= perCnt + ONE;
      end
    end else begin
      preCnt <= preCnt + PRE_W'(1);
    end
  end

  assign pwmOut = cfg.run & active & (perCnt < actDuty);
endmodule

// File: rtl/pwm_quad.sv
`timescale 1ns/1ps
module pwm_quad
  import pwm_quad_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic [NUM_CH-1:0] pwmOut
);
  chanCfg_t [NUM_CH-1:0] cfg;
  logic                  masterOn;
  logic [NUM_CH-1:0]     chanOn;

  pwm_quad_regs #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) uRegs (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .cfg(cfg),
    .masterOn(masterOn), .chanOn(chanOn)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : gChan
    pwm_quad_chan uChan (
      .clk(clk), .rstN(rstN), .cfg(cfg[i]), .pwmOut(pwmOut[i])
    );
  end
endmodule

// File: rtl/pwm_quad_chk.sv
`timescale 1ns/1ps
module pwm_quad_chk #(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic              rdEn,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wrData,
  input logic [DATA_W-1:0] rdData,
  input logic [NUM_CH-1:0] pwmOut,
  input logic              masterOn,
  input logic [NUM_CH-1:0] chanOn
);
  logic inBank, isMaster, mapped, isCtrl;
  assign inBank   = int'(addr[ADDR_W-1:4]) < NUM_CH;
  assign isMaster = (addr == ADDR_W'(8'h3C));
  assign isCtrl   = inBank && (addr[3:0] == 4'h0);
  assign mapped   = isMaster ||
                    (inBank && (addr[3:0] == 4'h0 || addr[3:0] == 4'h4 || addr[3:0] == 4'h8));

  // R8: global enable low silences every output
  a_r8_master_gate: assert property (@(posedge clk) disable iff (!rstN)
    !masterOn |-> (pwmOut == '0));

  // R7: a channel whose own enable is clear stays low
  a_r7_chan_gate: assert property (@(posedge clk) disable iff (!rstN)
    (pwmOut & ~chanOn) == '0);

  // R2: unmapped reads return zero
  a_r2_unmapped_zero: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && !mapped) |-> (rdData == '0));

  // R3: control word reads back exactly what the previous cycle wrote
  a_r3_ctrl_readback: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && isCtrl && $past(wrEn) && addr == $past(addr)) |-> (rdData == $past(wrData)));
endmodule

bind pwm_quad pwm_quad_chk #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) uChk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr), .wrData(wrData),
  .rdData(rdData), .pwmOut(pwmOut), .masterOn(masterOn), .chanOn(chanOn)
);

// File: tb/sim_pwm_quad.sv
`timescale 1ns/1ps
module sim_pwm_quad;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wrData = '0;
  wire  [31:0] rdData;
  wire  [3:0]  pwmOut;

  always #2.5 clk = ~clk;

  pwm_quad u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .pwmOut(pwmOut)
  );

  int nChecks = 0;
  int nFail = 0;
  localparam int LIM = 5000;

  typedef struct packed {
    int ch; int pre; int duty; int per; int expHi; int expPer;
  } vec_t;
  localparam int NV = 7;
  // expHi = (pre+1)*duty, expPer = (pre+1)*per; expHi==expPer means constant high
  localparam vec_t VECS [NV] = '{
    '{0, 0,   3,  8,   3,   8},
    '{1, 2,   5, 10,  15,  30},
    '{2, 9,   2,  4,  20,  40},
    '{3, 0,   1,  2,   1,   2},
    '{1, 0,   8,  8,   8,   8},
    '{2, 1,  20,  6,  12,  12},
    '{3, 255, 1,  3, 256, 768}
  };

  task automatic chk(input string req, input longint act, input longint exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // tasks start and end on a falling edge
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    addr = a; rdEn = 1'b1;
    #1 d = rdData;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic measure(input int ch, output int hi, output int per);
    int c, lo;
    c = 0; hi = 0; lo = 0;
    while (pwmOut[ch] === 1'b1 && c < LIM) begin @(negedge clk); c++; end
    c = 0;
    while (pwmOut[ch] !== 1'b1 && c < LIM) begin @(negedge clk); c++; end
    while (pwmOut[ch] === 1'b1 && hi < LIM) begin hi++; @(negedge clk); end
    while (pwmOut[ch] !== 1'b1 && lo < LIM) begin lo++; @(negedge clk); end
    per = hi + lo;
  endtask

  task automatic countHigh(input int ch, input int n, output int h);
    h = 0;
    for (int k = 0; k < n; k++) begin
      if (pwmOut[ch] === 1'b1) h++;
      @(negedge clk);
    end
  endtask

  initial begin : watchdog
    #1_000_000;
    nChecks++; nFail++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin : main
    logic [31:0] d;
    int hi, per, h, c;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    chk("R1 outputs", pwmOut, 0);
    for (int ch = 0; ch < 4; ch++) begin
      rd(8'(ch * 16),     d); chk("R1 ctrl",   d, 0);
      rd(8'(ch * 16 + 4), d); chk("R1 duty",   d, 0);
      rd(8'(ch * 16 + 8), d); chk("R1 period", d, 0);
    end
    rd(8'h3C, d); chk("R1 master", d, 0);

    // R2: map and unmapped addresses
    wr(8'h14, 32'h0000_0123);
    rd(8'h14, d); chk("R2 bank1 duty", d, 32'h123);
    rd(8'h04, d); chk("R2 bank0 duty untouched", d, 0);
    wr(8'h0C, 32'hFFFF_FFFF);
    wr(8'h40, 32'hFFFF_FFFF);
    rd(8'h0C, d); chk("R2 unmapped 0x0C", d, 0);
    rd(8'h40, d); chk("R2 unmapped 0x40", d, 0);
    rd(8'hFC, d); chk("R2 unmapped 0xFC", d, 0);
    for (int ch = 0; ch < 4; ch++) begin
      rd(8'(ch * 16), d); chk("R2 ctrl after stray writes", d, 0);
    end
    wr(8'h14, 32'h0);

    // R3: read-back widths
    wr(8'h20, 32'hA5A5_5A5A);
    rd(8'h20, d); chk("R3 ctrl exact", d, 32'hA5A5_5A5A);
    wr(8'h24, 32'h1234_ABCD);
    rd(8'h24, d); chk("R3 duty low half", d, 32'h0000_ABCD);
    wr(8'h38, 32'hFFFF_FFFF);
    rd(8'h38, d); chk("R3 period low half", d, 32'h0000_FFFF);
    wr(8'h3C, 32'hFFFF_FFFE);
    rd(8'h3C, d); chk("R3 master bit0 only", d, 0);
    wr(8'h3C, 32'hFFFF_FFFF);
    rd(8'h3C, d); chk("R3 master set", d, 1);
    wr(8'h3C, 32'h0);
    wr(8'h20, 32'h0); wr(8'h24, 32'h0); wr(8'h38, 32'h0);

    // R8: global enable gating
    wr(8'h04, 32'd2); wr(8'h08, 32'd4); wr(8'h00, 32'h1);
    countHigh(0, 40, h); chk("R8 low with master off", h, 0);
    wr(8'h3C, 32'h1);
    measure(0, hi, per);
    chk("R8 high after master on", hi, 2);
    chk("R8 period after master on", per, 4);
    wr(8'h3C, 32'h0);
    chk("R8 immediate low", pwmOut, 0);
    countHigh(0, 20, h); chk("R8 stays low", h, 0);
    wr(8'h00, 32'h0);
    wr(8'h3C, 32'h1);

    // R4 R5 R6: table walk
    for (int v = 0; v < NV; v++) begin
      int b;
      b = VECS[v].ch * 16;
      wr(8'(b + 4), 32'(VECS[v].duty));
      wr(8'(b + 8), 32'(VECS[v].per));
      wr(8'(b), 32'((VECS[v].pre << 2) | 1));
      rd(8'(b), d); chk("R4 ctrl enable and prescale", d, (VECS[v].pre << 2) | 1);
      if (VECS[v].expHi == VECS[v].expPer) begin
        @(negedge clk);
        countHigh(VECS[v].ch, 2 * VECS[v].expPer + 4, h);
        chk("R6 constant high", h, 2 * VECS[v].expPer + 4);
      end else begin
        measure(VECS[v].ch, hi, per);
        chk("R5 high time", hi, VECS[v].expHi);
        chk("R5 period", per, VECS[v].expPer);
      end
      chk("R10 other channels idle", pwmOut & ~(4'(1) << VECS[v].ch), 0);
      wr(8'(b), 32'(VECS[v].pre << 2));
      chk("R7 low after disable", pwmOut[VECS[v].ch], 0);
    end

    // R9: duty change mid-pulse takes effect next period
    wr(8'h04, 32'd4); wr(8'h08, 32'd10); wr(8'h00, 32'h1);
    c = 0;
    while (pwmOut[0] === 1'b1 && c < LIM) begin @(negedge clk); c++; end
    c = 0;
    while (pwmOut[0] !== 1'b1 && c < LIM) begin @(negedge clk); c++; end
    wr(8'h04, 32'd7);
    hi = 1;
    while (pwmOut[0] === 1'b1 && hi < LIM) begin hi++; @(negedge clk); end
    chk("R9 current pulse unchanged", hi, 4);
    measure(0, hi, per);
    chk("R9 new duty next period", hi, 7);
    chk("R9 period kept", per, 10);
    wr(8'h00, 32'h0);

    // R7: re-enable restarts counters
    wr(8'h04, 32'd4); wr(8'h08, 32'd10); wr(8'h00, 32'h0D);
    c = 0;
    while (pwmOut[0] !== 1'b1 && c < LIM) begin @(negedge clk); c++; end
    repeat (5) @(negedge clk);
    wr(8'h00, 32'h0C);
    chk("R7 disable mid-pulse", pwmOut[0], 0);
    repeat (3) @(negedge clk);
    wr(8'h00, 32'h0D);
    c = 0;
    while (pwmOut[0] !== 1'b1 && c < 10) begin @(negedge clk); c++; end
    chk("R7 restart latency", c, 1);
    hi = 0;
    while (pwmOut[0] === 1'b1 && hi < LIM) begin hi++; @(negedge clk); end
    chk("R7 full first pulse", hi, 16);
    wr(8'h00, 32'h0);

    // R10: two channels at once
    wr(8'h14, 32'd2); wr(8'h18, 32'd5); wr(8'h10, 32'h1);
    wr(8'h24, 32'd3); wr(8'h28, 32'd4); wr(8'h20, 32'h5);
    measure(1, hi, per);
    chk("R10 ch1 high", hi, 2); chk("R10 ch1 period", per, 5);
    measure(2, hi, per);
    chk("R10 ch2 high", hi, 6); chk("R10 ch2 period", per, 8);

    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule